// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vectorised load or store request into a series of per-element memory requests. A request brings the vector length, a signed immediate already widened to address width, an operation width code, a flag that selects the register-offset form (base plus offset register) over the immediate form, a flag per operand saying whether it is scalar or vector, a stride bit, a post-increment bit, an optional base-update target, and two predicate masks: one for the sources and one for the destination.

While a sequence runs, the block reads the base and offset register values through two same-cycle read ports. It presents one element at a time on a valid/ready output. Each element carries an effective address, the destination element index and, when update is enabled, the update element index and the value to write back. The address mode comes from the scalar/vector flags and the stride bit. The mode is unit stride, element stride, per-element indexed, or broadcast of one address. Memory access, data alignment and vector-length truncation are the work of neighbouring blocks.

Top module: `vls_addr_seq`

## Requirements
- R1: After reset, req_ready is 1, el_valid is 0 and done is 0.
- R2: In immediate form with a scalar base and stride bit 0, the address of destination element j is base + imm + j*2^w, where the width code w selects 0=1, 1=2, 2=4 or 3=8 bytes.
- R3: In immediate form with a scalar base, stride bit 1 and a nonzero immediate, the address of destination element j is base + imm*j.
- R4: In immediate form with a scalar base, stride bit 1 and a zero immediate, every element uses the address base (broadcast).
- R5: In immediate form with a vector base, element address is base register value at base index i, plus imm, and rd_base_idx shows i.
- R6: In register-offset form with stride bit 1 and both base and offset scalar, the address is base + offset*j. Otherwise it is base[i] + offset[k], and a scalar operand is read at index 0.
- R7: With post-increment, the element address is the base value alone, and el_upd_val is the base value plus the addend (the immediate, or the offset register in register-offset form). Without post-increment, el_upd_val equals el_addr.
- R8: Each vector operand index moves to the next set bit of its mask before use. The source mask governs the base, offset and update indices. The destination mask governs the destination index.
- R9: When the destination is scalar, the sequence ends after the first accepted element.
- R10: The sequence ends without issuing a further element when any vector index finds no set mask bit below VL. With VL = 0 no element is issued.
- R11: While el_valid is 1 and el_ready is 0, the element stays presented unchanged. Indices advance only on an accepted element.
- R12: A request is taken only when req_ready is 1, and req_ready is 0 for the whole sequence. done is a one-cycle pulse in the first cycle req_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_vl | input | CW (7) | Vector length, 0 to MAXVL |
| req_reg_form | input | 1 | 1 = base plus offset register, 0 = base plus immediate |
| req_imm | input | AW (64) | Sign-extended immediate |
| req_width | input | 2 | Operation width code, bytes = 2^code |
| req_stride | input | 1 | Element-stride select bit |
| req_postinc | input | 1 | Post-increment select |
| req_base_vec | input | 1 | Base operand is a vector |
| req_offs_vec | input | 1 | Offset operand is a vector (register-offset form) |
| req_dst_vec | input | 1 | Destination is a vector |
| req_upd_en | input | 1 | Base-update write requested |
| req_upd_vec | input | 1 | Update target is a vector |
| req_src_mask | input | MAXVL (64) | Source predicate mask |
| req_dst_mask | input | MAXVL (64) | Destination predicate mask |
| rd_base_idx | output | IW (6) | Base register element read index |
| rd_base_data | input | AW (64) | Base register value at rd_base_idx |
| rd_offs_idx | output | IW (6) | Offset register element read index |
| rd_offs_data | input | AW (64) | Offset register value at rd_offs_idx |
| el_valid | output | 1 | Element request present |
| el_ready | input | 1 | Downstream accepts element |
| el_addr | output | AW (64) | Effective address |
| el_dst_idx | output | IW (6) | Destination element index |
| el_upd_en | output | 1 | Update write requested for this element |
| el_upd_idx | output | IW (6) | Update target element index |
| el_upd_val | output | AW (64) | Value to write to the update target |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Every clock, the assertions check the handshake hold rule, that elements appear only while the sequencer is busy, that done lasts one cycle, and that a scalar destination gets just one element. They also check that every presented destination or vector base index has its predicate bit set and lies below VL. Only the bench scenarios show that each addressing mode gives the right address, that post-increment splits the address from the update value, and that sequences with sparse masks end with exactly the right element count. They also show that VL = 0 and an all-clear mask issue nothing, and that a request raised mid-sequence changes nothing.

// File: rtl/vls_pkg.sv
// Package: shared types for the vector load/store address sequencer.
// Assumes: no state; types only.
package vls_pkg;

    // Address formation mode chosen when a request is taken.
    typedef enum logic [1:0] {
        AM_UNIT  = 2'd0,   // base + imm + j*opbytes
        AM_ELEM  = 2'd1,   // base + addend*j
        AM_INDEX = 2'd2,   // base[i] + addend
        AM_SPLAT = 2'd3    // base + imm, same every element
    } addr_mode_e;

    // Sequencer control state.
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    // Operand lane numbering used by the index generators.
    localparam int unsigned LANE_BASE = 0;
    localparam int unsigned LANE_OFFS = 1;
    localparam int unsigned LANE_UPD  = 2;
    localparam int unsigned LANE_DST  = 3;
    localparam int unsigned NUM_LANES = 4;

endpackage

// File: rtl/vls_mode_dec.sv
// Module: vls_mode_dec
// Picks the address mode from the operand scalar/vector flags, the stride
// bit and whether the immediate is zero. Purely combinational.
// Assumes: offs_vec is only meaningful in register-offset form.
module vls_mode_dec
    import vls_pkg::*;
(
    input  logic       reg_form,
    input  logic       base_vec,
    input  logic       offs_vec,
    input  logic       stride,
    input  logic       imm_zero,
    output addr_mode_e mode
);

    // Decode priority: vector base first, then stride bit, then immediate.
    always_comb begin
        if (reg_form) begin
            if (stride && !base_vec && !offs_vec) mode = AM_ELEM;
            else                                  mode = AM_INDEX;
        end else begin
            if (base_vec)      mode = AM_INDEX;
            else if (!stride)  mode = AM_UNIT;
            else if (!imm_zero) mode = AM_ELEM;
            else               mode = AM_SPLAT;
        end
    end

endmodule

// File: rtl/vls_next_set.sv
// Module: vls_next_set
// Finds the lowest set mask bit at or above 'from' and below 'limit'.
// Assumes: from and limit are in 0..N; found is 0 if no such bit exists.
module vls_next_set #(
    parameter int N  = 64,
    parameter int IW = $clog2(N),
    parameter int CW = IW + 1
) (
    input  logic [N-1:0]  mask,
    input  logic [CW-1:0] from,
    input  logic [CW-1:0] limit,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest qualifying bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = N - 1; b >= 0; b--) begin
            if (mask[b] && (CW'(b) >= from) && (CW'(b) < limit)) begin
                found = 1'b1;
                idx   = IW'(b);
            end
        end
    end

endmodule

// File: rtl/vls_agen.sv
// Module: vls_agen
// Forms the effective address and the base-update value for one element.
// Assumes: base/offs data are the register values already read for the
// current indices; j is the destination element index.
module vls_agen
    import vls_pkg::*;
#(
    parameter int AW = 64,
    parameter int IW = 6
) (
    input  addr_mode_e    mode,
    input  logic          reg_form,
    input  logic          postinc,
    input  logic [1:0]    width,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] base_data,
    input  logic [AW-1:0] offs_data,
    input  logic [IW-1:0] j,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] upd_val
);

    logic [AW-1:0] addend;
    logic [AW-1:0] lin;

    // Second term of the sum: offset register or immediate.
    assign addend = reg_form ? offs_data : imm;

    // Mode-dependent linear address.
    always_comb begin
        case (mode)
            AM_UNIT:  lin = base_data + imm + (AW'(j) << width);
            AM_ELEM:  lin = base_data + addend * AW'(j);
            AM_INDEX: lin = base_data + addend;
            default:  lin = base_data + imm;
        endcase
    end

    // Post-increment uses the bare base and writes back base + addend.
    always_comb begin
        if (postinc) begin
            ea      = base_data;
            upd_val = base_data + addend;
        end else begin
            ea      = lin;
            upd_val = lin;
        end
    end

endmodule

// File: rtl/vls_addr_seq.sv
// Module: vls_addr_seq (top)
// Takes one vector load/store request and issues one element request per
// cycle on a valid/ready port, skipping masked elements per operand lane.
// Assumes: register read ports return data in the same cycle; a new
// request is taken only when idle.
module vls_addr_seq
    import vls_pkg::*;
#(
    parameter int AW    = 64,
    parameter int MAXVL = 64,
    localparam int IW   = $clog2(MAXVL),
    localparam int CW   = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CW-1:0]    req_vl,
    input  logic             req_reg_form,
    input  logic [AW-1:0]    req_imm,
    input  logic [1:0]       req_width,
    input  logic             req_stride,
    input  logic             req_postinc,
    input  logic             req_base_vec,
    input  logic             req_offs_vec,
    input  logic             req_dst_vec,
    input  logic             req_upd_en,
    input  logic             req_upd_vec,
    input  logic [MAXVL-1:0] req_src_mask,
    input  logic [MAXVL-1:0] req_dst_mask,
    output logic [IW-1:0]    rd_base_idx,
    input  logic [AW-1:0]    rd_base_data,
    output logic [IW-1:0]    rd_offs_idx,
    input  logic [AW-1:0]    rd_offs_data,
    output logic             el_valid,
    input  logic             el_ready,
    output logic [AW-1:0]    el_addr,
    output logic [IW-1:0]    el_dst_idx,
    output logic             el_upd_en,
    output logic [IW-1:0]    el_upd_idx,
    output logic [AW-1:0]    el_upd_val,
    output logic             done
);

    seq_state_e st_q;
    logic       done_q;

    // Captured request fields.
    addr_mode_e       mode_q, mode_d;
    logic [CW-1:0]    vl_q;
    logic             form_q, postinc_q, upd_en_q;
    logic             base_vec_q, offs_vec_q, dst_vec_q, upd_vec_q;
    logic [1:0]       width_q;
    logic [AW-1:0]    imm_q;
    logic [MAXVL-1:0] smask_q, dmask_q;

    // Per-lane index machinery.
    logic [NUM_LANES-1:0]         lane_vec;
    logic [NUM_LANES-1:0]         lane_ok;
    logic [NUM_LANES-1:0]         ns_found;
    logic [NUM_LANES-1:0][IW-1:0] ns_idx;
    logic [NUM_LANES-1:0][IW-1:0] eff;
    logic [NUM_LANES-1:0][CW-1:0] pos_q;

    logic accept, active, hs, finish;

    assign req_ready = (st_q == SQ_IDLE);
    assign accept    = req_valid && req_ready;

    // Mode is decoded from the request as it is taken.
    vls_mode_dec u_dec (
        .reg_form (req_reg_form),
        .base_vec (req_base_vec),
        .offs_vec (req_offs_vec),
        .stride   (req_stride),
        .imm_zero (req_imm == '0),
        .mode     (mode_d)
    );

    // Request capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= AM_UNIT;
            vl_q       <= '0;
            form_q     <= 1'b0;
            postinc_q  <= 1'b0;
            upd_en_q   <= 1'b0;
            base_vec_q <= 1'b0;
            offs_vec_q <= 1'b0;
            dst_vec_q  <= 1'b0;
            upd_vec_q  <= 1'b0;
            width_q    <= '0;
            imm_q      <= '0;
            smask_q    <= '0;
            dmask_q    <= '0;
        end else if (accept) begin
            mode_q     <= mode_d;
            vl_q       <= req_vl;
            form_q     <= req_reg_form;
            postinc_q  <= req_postinc;
            upd_en_q   <= req_upd_en;
            base_vec_q <= req_base_vec;
            offs_vec_q <= req_reg_form && req_offs_vec;
            dst_vec_q  <= req_dst_vec;
            upd_vec_q  <= req_upd_en && req_upd_vec;
            width_q    <= req_width;
            imm_q      <= req_imm;
            smask_q    <= req_src_mask;
            dmask_q    <= req_dst_mask;
        end
    end

    assign lane_vec[LANE_BASE] = base_vec_q;
    assign lane_vec[LANE_OFFS] = offs_vec_q;
    assign lane_vec[LANE_UPD]  = upd_vec_q;
    assign lane_vec[LANE_DST]  = dst_vec_q;

    // One next-set-bit finder per operand lane; destination uses its own mask.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        vls_next_set #(.N(MAXVL)) u_ns (
            .mask  ((g == LANE_DST) ? dmask_q : smask_q),
            .from  (pos_q[g]),
            .limit (vl_q),
            .found (ns_found[g]),
            .idx   (ns_idx[g])
        );
        assign lane_ok[g] = lane_vec[g] ? ns_found[g] : (vl_q != '0);
        assign eff[g]     = lane_vec[g] ? ns_idx[g]   : '0;
    end

    assign active   = &lane_ok;
    assign el_valid = (st_q == SQ_RUN) && active;
    assign hs       = el_valid && el_ready;
    assign finish   = (st_q == SQ_RUN) && (!active || (hs && !dst_vec_q));

    // Lane positions: clear on accept, step past the used index on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (accept) begin
            pos_q <= '0;
        end else if (hs) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (lane_vec[l]) pos_q[l] <= CW'(eff[l]) + CW'(1);
            end
        end
    end

    // Control state and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept)      st_q <= SQ_RUN;
            else if (finish) st_q <= SQ_IDLE;
        end
    end

    assign done        = done_q;
    assign rd_base_idx = eff[LANE_BASE];
    assign rd_offs_idx = eff[LANE_OFFS];
    assign el_dst_idx  = eff[LANE_DST];
    assign el_upd_idx  = eff[LANE_UPD];
    assign el_upd_en   = upd_en_q;

    vls_agen #(.AW(AW), .IW(IW)) u_agen (
        .mode      (mode_q),
        .reg_form  (form_q),
        .postinc   (postinc_q),
        .width     (width_q),
        .imm       (imm_q),
        .base_data (rd_base_data),
        .offs_data (rd_offs_data),
        .j         (eff[LANE_DST]),
        .ea        (el_addr),
        .upd_val   (el_upd_val)
    );

    // Elements appear only while a sequence runs.
    p_valid_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> !req_ready);

    // End pulse lasts one cycle.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A stalled element is held unchanged.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && !el_ready |=> el_valid && $stable(el_dst_idx)
            && $stable(rd_base_idx) && $stable(el_upd_idx));

    // Vector destination and base indices always land on enabled elements.
    p_dst_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && dst_vec_q |-> dmask_q[el_dst_idx]);
    p_base_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && base_vec_q |-> smask_q[rd_base_idx]);

    // No element at or beyond VL.
    p_below_vl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> (CW'(el_dst_idx) < vl_q));

    // Scalar destination: nothing after the first accepted element.
    p_scalar_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && el_ready && !dst_vec_q |=> !el_valid);

endmodule

// File: tb/vls_addr_seq_tb.sv
// Bench: behavioural reference builds the expected element list per request
// and compares the design's element port on every clock.
module vls_addr_seq_tb;

    localparam int AW = 64;
    localparam int MV = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [6:0]    req_vl = '0;
    logic          req_reg_form = 1'b0;
    logic [AW-1:0] req_imm = '0;
    logic [1:0]    req_width = '0;
    logic          req_stride = 1'b0, req_postinc = 1'b0;
    logic          req_base_vec = 1'b0, req_offs_vec = 1'b0, req_dst_vec = 1'b0;
    logic          req_upd_en = 1'b0, req_upd_vec = 1'b0;
    logic [MV-1:0] req_src_mask = '0, req_dst_mask = '0;
    logic [5:0]    rd_base_idx, rd_offs_idx;
    logic [AW-1:0] rd_base_data, rd_offs_data;
    logic          el_valid, el_ready = 1'b1;
    logic [AW-1:0] el_addr, el_upd_val;
    logic [5:0]    el_dst_idx, el_upd_idx;
    logic          el_upd_en, done;

    logic [AW-1:0] brf [MV];
    logic [AW-1:0] orf [MV];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rd_base_data = brf[rd_base_idx];
    assign rd_offs_data = orf[rd_offs_idx];

    vls_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vl(req_vl), .req_reg_form(req_reg_form), .req_imm(req_imm),
        .req_width(req_width), .req_stride(req_stride), .req_postinc(req_postinc),
        .req_base_vec(req_base_vec), .req_offs_vec(req_offs_vec),
        .req_dst_vec(req_dst_vec), .req_upd_en(req_upd_en), .req_upd_vec(req_upd_vec),
        .req_src_mask(req_src_mask), .req_dst_mask(req_dst_mask),
        .rd_base_idx(rd_base_idx), .rd_base_data(rd_base_data),
        .rd_offs_idx(rd_offs_idx), .rd_offs_data(rd_offs_data),
        .el_valid(el_valid), .el_ready(el_ready), .el_addr(el_addr),
        .el_dst_idx(el_dst_idx), .el_upd_en(el_upd_en), .el_upd_idx(el_upd_idx),
        .el_upd_val(el_upd_val), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic run_req(input bit rf, input bit bv, input bit ov, input bit dv,
                           input bit ue, input bit uv, input bit st, input bit pi,
                           input logic [1:0] w, input logic [63:0] imm, input int vl,
                           input logic [63:0] sm, input logic [63:0] dm,
                           input bit stall, input bit poke, input string rq);
        logic [63:0] qa[$];
        logic [63:0] qv[$];
        int          qd[$];
        int          qu[$];
        int          qb[$];
        int          pos[4];
        int          e[4];
        bit          vec[4];
        bit          ok, prev_stall, seen_done;
        logic [63:0] bval, oval, adn, addr, uval, p_addr;
        int          p_dst, n;
        vec[0] = bv; vec[1] = rf && ov; vec[2] = ue && uv; vec[3] = dv;
        for (int l = 0; l < 4; l++) pos[l] = 0;
        // Reference: walk the element loop from the requirements.
        forever begin
            ok = 1'b1;
            for (int l = 0; l < 4; l++) begin
                logic [63:0] m;
                bit f;
                m = (l == 3) ? dm : sm;
                f = 1'b0;
                e[l] = 0;
                if (vec[l]) begin
                    for (int b = pos[l]; b < vl; b++) begin
                        if (!f && m[b]) begin f = 1'b1; e[l] = b; end
                    end
                end else f = (vl > 0);
                if (!f) ok = 1'b0;
            end
            if (!ok) break;
            bval = brf[e[0]];
            oval = orf[e[1]];
            adn  = rf ? oval : imm;
            if (pi) begin
                addr = bval; uval = bval + adn;
            end else begin
                if (!rf) begin
                    if (bv)            addr = bval + imm;
                    else if (!st)      addr = bval + imm + (64'(e[3]) << w);
                    else if (imm != 0) addr = bval + imm * 64'(e[3]);
                    else               addr = bval;
                end else begin
                    if (st && !bv && !ov) addr = bval + oval * 64'(e[3]);
                    else                  addr = bval + oval;
                end
                uval = addr;
            end
            qa.push_back(addr); qv.push_back(uval);
            qd.push_back(e[3]); qu.push_back(e[2]); qb.push_back(e[0]);
            if (!dv) break;
            for (int l = 0; l < 4; l++) if (vec[l]) pos[l] = e[l] + 1;
        end
        // Issue the request.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_reg_form = rf; req_base_vec = bv; req_offs_vec = ov; req_dst_vec = dv;
        req_upd_en = ue; req_upd_vec = uv; req_stride = st; req_postinc = pi;
        req_width = w; req_imm = imm; req_vl = 7'(vl); req_src_mask = sm;
        req_dst_mask = dm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        prev_stall = 1'b0; seen_done = 1'b0; p_addr = '0; p_dst = 0;
        for (n = 0; n < 2000 && !seen_done; n++) begin
            el_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (poke && n == 1) begin
                // R12: request raised mid-sequence must be ignored
                req_valid = 1'b1; req_imm = 64'hdead; req_base_vec = 1'b1;
                req_dst_vec = 1'b0; req_vl = 7'd1;
            end else req_valid = 1'b0;
            if (prev_stall) begin
                chk(el_valid && el_addr == p_addr && int'(el_dst_idx) == p_dst,
                    "R11", {rq, " held element"}, el_addr, p_addr);
            end
            if (done) begin
                seen_done = 1'b1;
                chk(qa.size() == 0, "R10", {rq, " elements left at end"},
                    64'(qa.size()), 64'd0);
                chk(req_ready, "R12", {rq, " ready with done"}, 64'(req_ready), 64'd1);
            end
            if (el_valid) begin
                chk(!req_ready, "R12", {rq, " ready low while busy"},
                    64'(req_ready), 64'd0);
                if (qa.size() == 0) begin
                    chk(1'b0, "R10", {rq, " unexpected element"}, el_addr, 64'd0);
                end else begin
                    chk(el_addr == qa[0], rq, "address", el_addr, qa[0]);
                    chk(int'(el_dst_idx) == qd[0], "R8", {rq, " dst index"},
                        64'(el_dst_idx), 64'(qd[0]));
                    chk(int'(rd_base_idx) == qb[0], "R8", {rq, " base index"},
                        64'(rd_base_idx), 64'(qb[0]));
                    if (ue) begin
                        chk(el_upd_val == qv[0], "R7", {rq, " update value"},
                            el_upd_val, qv[0]);
                        chk(int'(el_upd_idx) == qu[0] && el_upd_en, "R8",
                            {rq, " update index"}, 64'(el_upd_idx), 64'(qu[0]));
                    end
                    if (el_ready) begin
                        void'(qa.pop_front()); void'(qv.pop_front());
                        void'(qd.pop_front()); void'(qu.pop_front());
                        void'(qb.pop_front());
                    end
                end
                prev_stall = !el_ready;
                p_addr = el_addr; p_dst = int'(el_dst_idx);
            end else prev_stall = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        el_ready = 1'b1;
        chk(seen_done, "R10", {rq, " sequence ended"}, 64'(seen_done), 64'd1);
        chk(!done, "R12", {rq, " done one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        for (int r = 0; r < MV; r++) begin
            brf[r] = 64'h1000_0000 + 64'(r) * 64'h100 + 64'(r * r);
            orf[r] = 64'(r * 24) - 64'd100;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
        chk(el_valid === 1'b0, "R1", "el_valid in reset", 64'(el_valid), 64'd0);
        chk(done === 1'b0, "R1", "done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: unit stride, 4-byte, all enabled
        run_req(0,0,0,1, 0,0,0,0, 2'd2, 64'd16, 8, '1, '1, 0, 0, "R2");
        // R2, R8, R11: unit stride, 8-byte, sparse dst mask, stalls
        run_req(0,0,0,1, 0,0,0,0, 2'd3, 64'd4, 8, '1, 64'hA6, 1, 0, "R2");
        // R3, R12: element stride with negative imm, poke while busy
        run_req(0,0,0,1, 0,0,1,0, 2'd0, -64'sd24, 6, '1, '1, 1, 1, "R3");
        // R4: broadcast
        run_req(0,0,0,1, 0,0,1,0, 2'd1, 64'd0, 5, '1, '1, 0, 0, "R4");
        // R5, R8, R10: vector base, sparse source mask ends sequence
        run_req(0,1,0,1, 0,0,0,0, 2'd3, 64'd8, 8, 64'hF3, '1, 1, 0, "R5");
        // R6: register form element stride
        run_req(1,0,0,1, 0,0,1,0, 2'd3, 64'd0, 7, '1, '1, 0, 0, "R6");
        // R6, R8: register form indexed, vector offset and update
        run_req(1,0,1,1, 1,1,0,0, 2'd3, 64'd0, 8, 64'hDB, '1, 1, 0, "R6");
        // R7: post-increment, vector base and update
        run_req(0,1,0,1, 1,1,0,1, 2'd3, 64'd40, 4, '1, '1, 0, 0, "R7");
        // R7: post-increment in register form, scalar update
        run_req(1,0,1,1, 1,0,0,1, 2'd2, 64'd0, 3, 64'h5, '1, 0, 0, "R7");
        // R9: scalar destination, vector base
        run_req(0,1,0,0, 0,0,0,0, 2'd3, 64'd12, 8, 64'hFC, '1, 1, 0, "R9");
        // R10: zero vector length
        run_req(0,0,0,1, 0,0,0,0, 2'd2, 64'd4, 0, '1, '1, 0, 0, "R10");
        // R10: destination mask clear below VL
        run_req(0,0,0,1, 0,0,0,0, 2'd2, 64'd4, 6, '1, 64'hFFC0, 0, 0, "R10");
        // R8: full-length sequence, alternating source mask
        run_req(0,1,0,1, 0,0,0,0, 2'd0, 64'd1, 64, 64'h5555_5555_5555_5555,
                '1, 0, 0, "R8");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule